// File: doc/BRIEF.md
# Masked Share Conversion Pipeline

This block converts secrets held as two masked shares from one masking domain to another. It also adds two boolean-masked secrets. It is a fixed-depth pipeline that accepts one 32-bit lane per clock, with no stall path. Each result leaves the pipeline a fixed number of cycles after its lane entered. A lane carries an operation code and four input shares (two pairs). It yields two result shares. The operation code is stored with the lane, so lanes that use different operations can follow each other on consecutive cycles.

Three operations are provided:

- **Arithmetic to boolean.** The first pair holds x as an arithmetic sharing modulo q. The block returns x as a boolean sharing.
- **Boolean to arithmetic.** The first pair holds x as a boolean sharing. The block returns x as an arithmetic sharing modulo q.
- **Masked add.** The block adds two boolean-shared words modulo 2^32. It returns the sum boolean-shared.

The modulus q is loaded from a configuration word by a load strobe. In the enclosing system this word is the low 32 bits of a wider modulus register. On the load, the block also computes the remasking value floor(q/3) once and keeps it. This fixed value takes the place of a fresh random mask. A status output stays high while any lane is still in flight.

Top module: `msc_share_pipe`

## Requirements
- R1: After synchronous reset, `res_vld_o` and `busy_o` are 0. Both result shares read 0 in every cycle in which `res_vld_o` is low.
- R2: A lane presented with `lane_vld_i` high in cycle n appears with `res_vld_o` high in cycle n+LATENCY, where LATENCY defaults to 32. A new lane is accepted every cycle and lanes leave in entry order.
- R3: Operation code 2'b00 (arithmetic to boolean) sets x = (a0 + a1) mod q. It returns share 0 = x XOR m and share 1 = m, where m = floor(q/3). The second input pair is ignored.
- R4: The modular sum in R3 is correct when a0 + a1 equals q exactly (x = 0). It is also correct when a0 + a1 carries beyond 32 bits, provided both operands are below q.
- R5: Operation code 2'b01 (boolean to arithmetic) sets x = b0 XOR b1. It returns share 0 = (x − m) mod q and share 1 = m. q is added back when x < m. The second input pair is ignored.
- R6: Operation code 2'b10 (masked add) sets x = in0 share0 XOR in0 share1 and y = in1 share0 XOR in1 share1. It returns share 0 = ((x + y) mod 2^32) XOR m and share 1 = m.
- R7: Operation code 2'b11 is reserved. Its lane still leaves with `res_vld_o` high, and both result shares are 0.
- R8: m = floor(q/3) is computed from the 32-bit word on `cfg_mod_i` in the cycle `cfg_load_i` is high. It is exact for every q up to 2^32−1.
- R9: `busy_o` is high in every cycle in which at least one valid lane is inside the pipeline, and low otherwise.
- R10: Each lane is processed with the operation code it carried when it entered, even when neighbouring lanes use other codes.
- R11: When `cfg_load_i` is low, changes on `cfg_mod_i` do not change q or m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load_i | input | 1 | Latch q from `cfg_mod_i` and compute the remask value |
| cfg_mod_i | input | 32 | Modulus q |
| lane_vld_i | input | 1 | Input lane valid |
| lane_op_i | input | 2 | Operation code (00 a2b, 01 b2a, 10 add, 11 reserved) |
| in0_s0_i | input | 32 | First pair, share 0 |
| in0_s1_i | input | 32 | First pair, share 1 |
| in1_s0_i | input | 32 | Second pair, share 0 |
| in1_s1_i | input | 32 | Second pair, share 1 |
| res_vld_o | output | 1 | Result lane valid |
| res_s0_o | output | 32 | Result share 0 |
| res_s1_o | output | 32 | Result share 1 |
| busy_o | output | 1 | A valid lane is in flight |

## Verification
A corrupted valid bit anywhere in the delay chain shows up in two ways. A result is lost, duplicated or moved by a cycle exactly LATENCY cycles after its lane entered. A corrupted valid bit also toggles `busy_o` at once. A wrong remask value or modulus is visible in share 1 of the next valid result. A wrong reduction step shows only in share 0 of lanes that sit right at q or carry past 32 bits. For that reason the stimulus includes those boundary lanes. An operation code that is mixed up between lanes shows up as a share 0 that matches a neighbour's operation, at that lane's exit cycle.

// File: rtl/msc_pkg.sv
package msc_pkg;

    localparam int unsigned SHARE_W = 32;

    typedef logic [SHARE_W-1:0] share_t;

    typedef enum logic [1:0] {
        OP_A2B  = 2'b00,
        OP_B2A  = 2'b01,
        OP_SADD = 2'b10,
        OP_RSVD = 2'b11
    } msc_op_e;

    typedef struct packed {
        logic    vld;
        msc_op_e op;
        share_t  p0s0;
        share_t  p0s1;
        share_t  p1s0;
        share_t  p1s1;
    } msc_lane_t;

    typedef struct packed {
        logic   vld;
        share_t r0;
        share_t r1;
    } msc_res_t;

    // (a + b) mod q for a, b < q, via a wide add and one conditional subtract
    function automatic share_t mod_add(share_t a, share_t b, share_t q);
        logic [SHARE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, q}) begin
            s = s - {1'b0, q};
        end
        return s[SHARE_W-1:0];
    endfunction

    // (a - b) mod q, adding q back on borrow
    function automatic share_t mod_sub(share_t a, share_t b, share_t q);
        logic [SHARE_W:0] d;
        d = {1'b0, a} - {1'b0, b};
        if (d[SHARE_W]) begin
            d = d + {1'b0, q};
        end
        return d[SHARE_W-1:0];
    endfunction

endpackage

// File: rtl/msc_mask_gen.sv
module msc_mask_gen
    import msc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  share_t mod_i,
    output share_t q_o,
    output share_t third_o
);
    // floor(q/3) = (q * ceil(2^(W+1)/3)) >> (W+1), exact for every W-bit q
    localparam int unsigned PW = 2 * SHARE_W + 2;
    localparam logic [PW-1:0] TWO_POW = PW'(1) << (SHARE_W + 1);
    localparam logic [PW-1:0] RECIP   = (TWO_POW + PW'(2)) / PW'(3);

    logic [PW-1:0] prod;
    logic [PW-1:0] quot;

    always_comb begin
        prod = {{(PW-SHARE_W){1'b0}}, mod_i} * RECIP;
        quot = prod >> (SHARE_W + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o     <= '0;
            third_o <= '0;
        end else if (load_i) begin
            q_o     <= mod_i;
            third_o <= quot[SHARE_W-1:0];
        end
    end
endmodule

// File: rtl/msc_share_alu.sv
module msc_share_alu
    import msc_pkg::*;
(
    input  msc_lane_t lane_i,
    input  share_t    q_i,
    input  share_t    third_i,
    output msc_res_t  res_o
);
    share_t x_bool;
    share_t y_bool;
    share_t sum_w;

    always_comb begin
        x_bool = lane_i.p0s0 ^ lane_i.p0s1;
        y_bool = lane_i.p1s0 ^ lane_i.p1s1;
        sum_w  = x_bool + y_bool;
        res_o  = '0;
        res_o.vld = lane_i.vld;
        if (lane_i.vld) begin
            unique case (lane_i.op)
                OP_A2B: begin
                    res_o.r0 = mod_add(lane_i.p0s0, lane_i.p0s1, q_i) ^ third_i;
                    res_o.r1 = third_i;
                end
                OP_B2A: begin
                    res_o.r0 = mod_sub(x_bool, third_i, q_i);
                    res_o.r1 = third_i;
                end
                OP_SADD: begin
                    res_o.r0 = sum_w ^ third_i;
                    res_o.r1 = third_i;
                end
                default: begin
                    res_o.r0 = '0;
                    res_o.r1 = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/msc_delay.sv
module msc_delay
    import msc_pkg::*;
#(
    parameter int unsigned DEPTH = 30
) (
    input  logic     clk,
    input  logic     rst,
    input  msc_res_t d_i,
    output msc_res_t q_o,
    output logic     any_vld_o
);
    msc_res_t         stg [DEPTH];
    logic [DEPTH-1:0] vld_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        msc_res_t nxt;
        if (i == 0) begin : g_head
            assign nxt = d_i;
        end else begin : g_body
            assign nxt = stg[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[i] <= '0;
            end else begin
                stg[i] <= nxt.vld ? nxt : '0;
            end
        end
        assign vld_vec[i] = stg[i].vld;
    end

    assign q_o       = stg[DEPTH-1];
    assign any_vld_o = |vld_vec;
endmodule

// File: rtl/msc_share_pipe.sv
module msc_share_pipe
    import msc_pkg::*;
#(
    parameter int unsigned LATENCY = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_load_i,
    input  logic [31:0] cfg_mod_i,
    input  logic        lane_vld_i,
    input  logic [1:0]  lane_op_i,
    input  logic [31:0] in0_s0_i,
    input  logic [31:0] in0_s1_i,
    input  logic [31:0] in1_s0_i,
    input  logic [31:0] in1_s1_i,
    output logic        res_vld_o,
    output logic [31:0] res_s0_o,
    output logic [31:0] res_s1_o,
    output logic        busy_o
);
    // one capture stage, one compute stage, the rest pure delay
    localparam int unsigned DELAY_D = LATENCY - 2;

    share_t    q_cur;
    share_t    third_cur;
    msc_lane_t cap_q;
    msc_res_t  alu_res;
    msc_res_t  cmp_q;
    msc_res_t  tail;
    logic      tail_busy;

    msc_mask_gen u_mask (
        .clk     (clk),
        .rst     (rst),
        .load_i  (cfg_load_i),
        .mod_i   (cfg_mod_i),
        .q_o     (q_cur),
        .third_o (third_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (lane_vld_i) begin
            cap_q <= '{vld: 1'b1, op: msc_op_e'(lane_op_i),
                       p0s0: in0_s0_i, p0s1: in0_s1_i,
                       p1s0: in1_s0_i, p1s1: in1_s1_i};
        end else begin
            cap_q <= '0;
        end
    end

    msc_share_alu u_alu (
        .lane_i  (cap_q),
        .q_i     (q_cur),
        .third_i (third_cur),
        .res_o   (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= alu_res;
        end
    end

    msc_delay #(.DEPTH(DELAY_D)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .d_i       (cmp_q),
        .q_o       (tail),
        .any_vld_o (tail_busy)
    );

    assign res_vld_o = tail.vld;
    assign res_s0_o  = tail.r0;
    assign res_s1_o  = tail.r1;
    assign busy_o    = cap_q.vld | cmp_q.vld | tail_busy;
endmodule

// File: rtl/msc_checker.sv
module msc_checker #(
    parameter int unsigned LATENCY = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_load_i,
    input logic        lane_vld_i,
    input logic        res_vld_o,
    input logic [31:0] res_s0_o,
    input logic [31:0] res_s1_o,
    input logic        busy_o,
    input logic [31:0] q_cur,
    input logic [31:0] third_cur
);
    // independent record of lanes that entered, one bit per cycle
    logic [LATENCY-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else begin
            seen <= {seen[LATENCY-2:0], lane_vld_i};
        end
    end

    // R2: output valid follows input valid by exactly LATENCY cycles
    a_r2_exit_on_time: assert property (@(posedge clk) disable iff (rst)
        res_vld_o == seen[LATENCY-1]);

    // R1: idle outputs carry no data
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !res_vld_o |-> (res_s0_o == 32'd0 && res_s1_o == 32'd0));

    // R9: an accepted lane makes the block busy on the next cycle
    a_r9_busy_after_entry: assert property (@(posedge clk) disable iff (rst)
        lane_vld_i |=> busy_o);

    // R9: a leaving lane is still counted as in flight
    a_r9_busy_on_exit: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> busy_o);

    // R9: busy with nothing recorded in flight is wrong
    a_r9_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
        (seen == '0) |-> !busy_o);

    // R11: modulus and remask only move on a load
    a_r11_q_held: assert property (@(posedge clk) disable iff (rst)
        !cfg_load_i |=> $stable(q_cur));

    a_r11_mask_held: assert property (@(posedge clk) disable iff (rst)
        !cfg_load_i |=> $stable(third_cur));

    // R8: the remask never exceeds the modulus
    a_r8_mask_below_q: assert property (@(posedge clk) disable iff (rst)
        third_cur <= q_cur);
endmodule

bind msc_share_pipe msc_checker #(.LATENCY(LATENCY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_load_i (cfg_load_i),
    .lane_vld_i (lane_vld_i),
    .res_vld_o  (res_vld_o),
    .res_s0_o   (res_s0_o),
    .res_s1_o   (res_s1_o),
    .busy_o     (busy_o),
    .q_cur      (q_cur),
    .third_cur  (third_cur)
);

// File: tb/sim_msc_share_pipe.sv
module sim_msc_share_pipe;

    localparam int unsigned LAT   = 32;
    localparam int unsigned NVEC  = 10;
    localparam int unsigned WDOG  = 20000;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] d;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    // q = 3329 (0xD01), remask floor(q/3) = 1109 (0x455)
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 32'd1000,  32'd2000,  32'h0,   32'h0,  32'hFED, 32'h455}, // R3
        '{2'b00, 32'd3000,  32'd1000,  32'h77,  32'h88, 32'h6CA, 32'h455}, // R3 reduce
        '{2'b01, 32'h100,   32'h023,   32'h0,   32'h0,  32'h9CF, 32'h455}, // R5 borrow
        '{2'b01, 32'h800,   32'h000,   32'h5,   32'h6,  32'h3AB, 32'h455}, // R5
        '{2'b10, 32'hFFFF0000, 32'h0000FFFF, 32'h3, 32'h1, 32'h454, 32'h455}, // R6 wrap
        '{2'b10, 32'h12,    32'h34,    32'h0F,  32'hF0, 32'h570, 32'h455}, // R6
        '{2'b11, 32'h1234,  32'h5678,  32'h9,   32'hA,  32'h0,   32'h0},   // R7
        '{2'b00, 32'd3328,  32'd1,     32'h0,   32'h0,  32'h455, 32'h455}, // R4 sum==q
        '{2'b01, 32'h455,   32'h0,     32'h0,   32'h0,  32'h0,   32'h455}, // R5 x==m
        '{2'b10, 32'h0,     32'h0,     32'h0,   32'h0,  32'h455, 32'h455}  // R6 zero
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load_i = 1'b0;
    logic [31:0] cfg_mod_i = '0;
    logic        lane_vld_i = 1'b0;
    logic [1:0]  lane_op_i = '0;
    logic [31:0] in0_s0_i = '0;
    logic [31:0] in0_s1_i = '0;
    logic [31:0] in1_s0_i = '0;
    logic [31:0] in1_s1_i = '0;
    logic        res_vld_o;
    logic [31:0] res_s0_o;
    logic [31:0] res_s1_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    msc_share_pipe #(.LATENCY(LAT)) u0 (
        .clk(clk), .rst(rst), .cfg_load_i(cfg_load_i), .cfg_mod_i(cfg_mod_i),
        .lane_vld_i(lane_vld_i), .lane_op_i(lane_op_i),
        .in0_s0_i(in0_s0_i), .in0_s1_i(in0_s1_i),
        .in1_s0_i(in1_s0_i), .in1_s1_i(in1_s1_i),
        .res_vld_o(res_vld_o), .res_s0_o(res_s0_o), .res_s1_o(res_s1_o),
        .busy_o(busy_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_lane(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                              input logic [31:0] c, input logic [31:0] d);
        lane_vld_i = 1'b1;
        lane_op_i  = op;
        in0_s0_i   = a;
        in0_s1_i   = b;
        in1_s0_i   = c;
        in1_s1_i   = d;
    endtask

    task automatic idle_lane();
        lane_vld_i = 1'b0;
        lane_op_i  = '0;
        in0_s0_i   = '0;
        in0_s1_i   = '0;
        in1_s0_i   = '0;
        in1_s1_i   = '0;
    endtask

    task automatic load_mod(input logic [31:0] q);
        @(negedge clk);
        cfg_load_i = 1'b1;
        cfg_mod_i  = q;
        @(negedge clk);
        cfg_load_i = 1'b0;
    endtask

    // one lane alone; result sampled LAT negedges after driving
    task automatic single(input string req, input logic [1:0] op,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d,
                          input logic [31:0] e0, input logic [31:0] e1);
        @(negedge clk);
        drive_lane(op, a, b, c, d);
        @(negedge clk);
        idle_lane();
        for (int k = 2; k < LAT; k++) @(negedge clk);
        chk({req, " early"}, {31'd0, res_vld_o}, 32'd0);
        @(negedge clk);
        chk({req, " valid"}, {31'd0, res_vld_o}, 32'd1);
        chk({req, " share0"}, res_s0_o, e0);
        chk({req, " share1"}, res_s1_o, e1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 vld", {31'd0, res_vld_o}, 32'd0);
        chk("R1 busy", {31'd0, busy_o}, 32'd0);
        chk("R1 s0", res_s0_o, 32'd0);
        chk("R1 s1", res_s1_o, 32'd0);

        load_mod(32'd3329);

        // R2 R10 back-to-back mixed stream from the table
        for (int i = 0; i < int'(NVEC); i++) begin
            @(negedge clk);
            drive_lane(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].d);
            if (i == 0) begin
                @(posedge clk);
                @(negedge clk);
                chk("R9 busy after entry", {31'd0, busy_o}, 32'd1);
                drive_lane(VECS[1].op, VECS[1].a, VECS[1].b, VECS[1].c, VECS[1].d);
                i = 1;
            end
        end
        @(negedge clk);
        idle_lane();
        // now at negedge NVEC; first lane exits at negedge LAT
        for (int k = NVEC; k < LAT - 1; k++) @(negedge clk);
        chk("R2 not before latency", {31'd0, res_vld_o}, 32'd0);
        for (int i = 0; i < int'(NVEC); i++) begin
            @(negedge clk);
            chk($sformatf("R2 R10 vec%0d valid", i), {31'd0, res_vld_o}, 32'd1);
            chk($sformatf("R10 vec%0d share0", i), res_s0_o, VECS[i].e0);
            chk($sformatf("R10 vec%0d share1", i), res_s1_o, VECS[i].e1);
            chk($sformatf("R9 vec%0d busy", i), {31'd0, busy_o}, 32'd1);
        end
        @(negedge clk);
        chk("R2 no extra lane", {31'd0, res_vld_o}, 32'd0);
        chk("R9 idle after drain", {31'd0, busy_o}, 32'd0);
        chk("R1 idle s0", res_s0_o, 32'd0);

        // R11 modulus change without load is ignored
        @(negedge clk);
        cfg_mod_i = 32'd7;
        single("R11 unloaded mod", 2'b00, 32'd1000, 32'd2000, 32'h0, 32'h0, 32'hFED, 32'h455);

        // R8 R4 full-range modulus, 33-bit carry
        load_mod(32'hFFFFFFFF);
        single("R4 R8 carry", 2'b00, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'h1, 32'h2,
               32'hAAAAAAA8, 32'h55555555);
        single("R8 b2a big q", 2'b01, 32'h0, 32'h0, 32'h0, 32'h0, 32'hAAAAAAAA, 32'h55555555);

        // R8 small modulus, remask 0
        load_mod(32'd2);
        single("R8 q2 b2a", 2'b01, 32'h1, 32'h0, 32'h0, 32'h0, 32'h1, 32'h0);
        load_mod(32'd100);
        single("R8 q100 add", 2'b10, 32'h0, 32'h0, 32'h0, 32'h0, 32'h21, 32'h21);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule